// File: doc/BRIEF.md
# Ticket Queue Lock

A hardware lock manager shared by N requesters that hands out ownership strictly in arrival order. A requester that raises its acquire line while idle is given the current value of a wrap-around tail counter as its place in line, and the counter steps forward. The block keeps one ready flag per place. Exactly one flag is set while the lock is free or being handed over.

A waiting requester watches the flag at its own place. When that flag is set, the block clears it and raises the requester's granted output. When the holder releases, the flag of the following place is set. The next waiter's grant then follows without any further read-modify-write on a shared counter. The tail counter is visible on an output so that it can be inspected.

Requesters that arrive in the same cycle are queued by index, lowest first. Each requester holds at most one place at a time. The line therefore never holds more than N places.

Top module: `ticket_lock`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, and right after it, every granted output is 0 and `tail_o` is 0.
- R2: Each accepted arrival advances `tail_o` by one modulo N. Several arrivals accepted in one cycle advance it by their count. A cycle with no acquire request leaves it unchanged.
- R3: Arrivals accepted in the same cycle are served lowest requester index first.
- R4: Arrivals accepted in different cycles are served in the order of their arrival cycles.
- R5: At most one bit of `gnt_o` is 1 in any cycle.
- R6: On a free lock, an acquire sampled at clock edge k gives a granted output that is 1 after edge k+1. A grant only rises for a requester that was waiting in line.
- R7: A release sampled at edge k from the holder clears its grant after edge k. The next waiter in line is granted after edge k+1.
- R8: A release from a requester that is not granted has no effect: no grant changes and no waiter is granted early.
- R9: An acquire from a requester that is already waiting or granted is ignored, and `tail_o` does not move.
- R10: A granted output stays 1 until its owner releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acq_i | input | N | Per-requester acquire request |
| rel_i | input | N | Per-requester release of a held lock |
| gnt_o | output | N | Per-requester lock-granted indication |
| tail_o | output | $clog2(N) | Next place to be handed out (debug read) |

## Verification
The bench builds the block with N = 4, so the tail counter is two bits wide and wraps every four places. Every one of the fifteen non-empty sets of simultaneous arrivals is swept in turn from a free lock, and each set's drain order and tail step is computed arithmetically. Because the tail keeps advancing, the sweep starts bursts from every slot, wraps the counter many times, and fills the line to full capacity. Directed sequences then cover staggered arrivals, stray releases, and repeated acquires.

// File: rtl/ticket_lock.sv
module ticket_lock #(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         acq_i,
  input  logic [N-1:0]         rel_i,
  output logic [N-1:0]         gnt_o,
  output logic [$clog2(N)-1:0] tail_o
);
  localparam int TW = $clog2(N);

  function automatic logic [TW-1:0] wrap_inc(input logic [TW-1:0] x);
    return (x == TW'(N - 1)) ? '0 : x + 1'b1;
  endfunction

  logic [N-1:0]  flag, flag_nxt;
  logic [N-1:0]  waiting;
  logic [N-1:0]  take;
  logic [TW-1:0] slot [N];
  logic [TW-1:0] tkt  [N];
  logic [TW-1:0] tail, tail_nxt;

  assign tail_o = tail;

  always_comb begin
    tail_nxt = tail;
    for (int i = 0; i < N; i++) begin
      take[i] = acq_i[i] & ~waiting[i] & ~gnt_o[i];
      tkt[i]  = tail_nxt;
      if (take[i]) tail_nxt = wrap_inc(tail_nxt);
    end
  end

  always_comb begin
    flag_nxt = flag;
    for (int i = 0; i < N; i++)
      if (waiting[i] && flag[slot[i]]) flag_nxt[slot[i]] = 1'b0;
    for (int i = 0; i < N; i++)
      if (gnt_o[i] && rel_i[i]) flag_nxt[wrap_inc(slot[i])] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail    <= '0;
      flag    <= N'(1);
      waiting <= '0;
      gnt_o   <= '0;
      for (int i = 0; i < N; i++) slot[i] <= '0;
    end else begin
      tail <= tail_nxt;
      flag <= flag_nxt;
      for (int i = 0; i < N; i++) begin
        if (take[i]) begin
          slot[i]    <= tkt[i];
          waiting[i] <= 1'b1;
        end else if (waiting[i] && flag[slot[i]]) begin
          waiting[i] <= 1'b0;
          gnt_o[i]   <= 1'b1;
        end else if (gnt_o[i] && rel_i[i]) begin
          gnt_o[i]   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ticket_lock_chk.sv
module ticket_lock_chk #(
  parameter int N  = 4,
  parameter int TW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  acq_i,
  input logic [N-1:0]  rel_i,
  input logic [N-1:0]  gnt_o,
  input logic [N-1:0]  waiting,
  input logic [TW-1:0] tail_o
);
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (gnt_o == '0 && tail_o == '0));

  p_mutex_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  p_tail_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_i == '0) |=> $stable(tail_o));

  for (genvar i = 0; i < N; i++) begin : g_req
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o[i] && !rel_i[i]) |=> gnt_o[i]);
    p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o[i] && rel_i[i]) |=> !gnt_o[i]);
    p_from_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gnt_o[i]) |-> $past(waiting[i]));
  end
endmodule

bind ticket_lock ticket_lock_chk #(.N(N), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acq_i(acq_i), .rel_i(rel_i),
  .gnt_o(gnt_o), .waiting(waiting), .tail_o(tail_o)
);

// File: tb/test_ticket_lock.sv
module test_ticket_lock;
  localparam int N = 4;
  localparam int PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] acq, rel;
  logic [N-1:0] gnt;
  logic [1:0]   tail;
  int errors = 0;
  int checks = 0;
  int exp_tail = 0;
  bit done = 0;

  always #(PERIOD / 2) clk = ~clk;

  ticket_lock #(.N(N)) i_ticket_lock (
    .clk(clk), .rst_n(rst_n), .acq_i(acq), .rel_i(rel),
    .gnt_o(gnt), .tail_o(tail)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  always @(negedge clk)
    if (rst_n === 1'b1 && !done) check("R5 mutual exclusion", 8'($onehot0(gnt)), 8'd1);

  task automatic serve(input int who);
    check("R4 R3 serving order", 8'(gnt), 8'(1 << who));
    tick();
    check("R10 grant held", 8'(gnt), 8'(1 << who));
    rel = N'(1 << who);
    tick();
    rel = '0;
    check("R7 grant drops on release", 8'(gnt), 8'd0);
    tick();
  endtask

  initial begin
    rst_n = 1'b0; acq = '0; rel = '0;
    tick(); tick();
    check("R1 reset grants", 8'(gnt), 8'd0);
    check("R1 reset tail", 8'(tail), 8'd0);
    rst_n = 1'b1;
    tick();
    check("R1 after reset", 8'(gnt), 8'd0);

    for (int m = 1; m < 16; m++) begin
      acq = N'(m);
      tick();
      acq = '0;
      exp_tail = (exp_tail + $countones(N'(m))) % N;
      check("R2 tail step", 8'(tail), 8'(exp_tail));
      check("R6 no grant before second edge", 8'(gnt), 8'd0);
      tick();
      for (int i = 0; i < N; i++)
        if (m[i]) serve(i);
      check("R7 lock idle after drain", 8'(gnt), 8'd0);
    end

    acq = 4'b1000; tick();
    acq = 4'b0010; tick();
    check("R6 first arrival granted", 8'(gnt), 8'b1000);
    acq = 4'b0100; tick();
    acq = '0;
    exp_tail = (exp_tail + 3) % N;
    check("R2 staggered tail", 8'(tail), 8'(exp_tail));
    rel = 4'b0110; tick();
    rel = '0;
    check("R8 stray release", 8'(gnt), 8'b1000);
    tick();
    check("R8 no early grant", 8'(gnt), 8'b1000);
    acq = 4'b1010; tick();
    acq = '0;
    check("R9 repeat acquire ignored", 8'(tail), 8'(exp_tail));
    serve(3);
    serve(1);
    serve(2);
    check("R4 drained", 8'(gnt), 8'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule